// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the command pins of a double-data-rate SDRAM on every rising clock edge and keeps a shadow of the device state that those commands produce. It turns the four active-low strobes into a command code. It records which of the four banks hold an open row and which row that is. It also keeps the mode register and the extended mode register, and exposes their fields. A command that the current state does not permit raises a one-cycle illegal flag and has no effect on the tracked state.

The tracker sits beside a memory controller or on a bus monitor. Its outputs tell the surrounding logic the burst length, CAS latency and bank state the device is now using. Auto precharge is modelled. A read or write with address bit 10 high keeps its bank open for the burst length divided by two clock cycles, and then marks the bank idle without any further command. While a burst runs, a mode-register load is rejected. The DLL-reset bit of the mode register clears itself one cycle after it is written.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: `cmd_o` shows, in the cycle after each rising edge, the code of the command sampled on that edge from {cs_n,ras_n,cas_n,we_n}. The codes are: cs_n high → 0 (deselect); 0111 → 1 (no-op); 0011 → 2 (activate); 0101 → 3 (read); 0100 → 4 (write); 0010 → 5 (precharge); 0001 → 6 (refresh); 0000 → 7 (mode load); 0110 → 8 (burst stop).
- R2: An activate to an idle bank sets that bank's bit in `bank_open` and stores `addr` as its row in `bank_row[b*13 +: 13]`. An activate to an open bank raises `illegal_o` and changes neither the bank bit nor the row.
- R3: A read or write to an idle bank, or to a bank whose auto precharge is pending, raises `illegal_o`. A read or write to an open bank with addr[10] low is legal and leaves the bank open.
- R4: A precharge with addr[10] low closes only the bank selected by `ba`. A precharge with addr[10] high closes all four banks.
- R5: A legal read or write with addr[10] high sets its bank idle on the edge that lies BL/2 edges after the command edge. BL comes from mode bits 2:0: 001 gives 2, 010 gives 4, 011 gives 8. On that same edge, another command to a different bank also takes effect.
- R6: A legal mode load with ba=00 writes `addr` into the mode register. `burst_len` is bits 2:0, `burst_interleave` is bit 3, `cas_lat` is bits 6:4 and `op_mode` is bits 12:7. A legal mode load with ba=01 writes all 13 bits to `ext_mode`.
- R7: Mode bit 8 (`op_mode[1]`) reads 1 in the cycle after a load that sets it, and reads 0 from the next edge on.
- R8: A mode load raises `illegal_o` and changes no register if any bank is open. It does the same within BL/2 edges after the edge of a legal read or write.
- R9: A mode load with ba=1x raises `illegal_o`. So does a load with ba=00 whose CAS field is not 010 or 110, or whose burst field is not 001, 010 or 011. In each case neither register changes.
- R10: A refresh while any bank is open raises `illegal_o`.
- R11: After reset, all banks are idle with rows 0. The mode register holds 0x021 (BL 2, sequential, CAS 2). The extended register holds 0. `cmd_o` reads 0 and `illegal_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row, column or register data |
| bank_open | output | 4 | One bit per bank, 1 = row open |
| bank_row | output | 52 | Open row of each bank, bank b at [b*13 +: 13] |
| burst_len | output | 3 | Mode bits 2:0 |
| burst_interleave | output | 1 | Mode bit 3 |
| cas_lat | output | 3 | Mode bits 6:4 |
| op_mode | output | 6 | Mode bits 12:7 |
| ext_mode | output | 13 | Extended mode register |
| cmd_o | output | 4 | Decoded command of the previous edge |
| illegal_o | output | 1 | Previous command was rejected |

## Verification
The auto-precharge countdown can end on the same edge as a new command. In a directed case, a bank's self-close lines up with a precharge to a second bank, and both banks must read idle together. A second case puts a mode load one edge before the countdown ends, and then on the first edge after it ends, so the load is rejected first and accepted next. The random phase uses burst lengths 2, 4 and 8 with mixed commands, so these collisions also happen by chance. An edge-by-edge bench model judges the result, with the countdown applied before the new command.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

   typedef enum logic [3:0] {
      CMD_DESEL = 4'd0,
      CMD_NOP   = 4'd1,
      CMD_ACT   = 4'd2,
      CMD_RD    = 4'd3,
      CMD_WR    = 4'd4,
      CMD_PRE   = 4'd5,
      CMD_REF   = 4'd6,
      CMD_MRS   = 4'd7,
      CMD_BST   = 4'd8
   } cmd_e;

   function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                       input logic cas_n, input logic we_n);
      if (cs_n) return CMD_DESEL;
      case ({ras_n, cas_n, we_n})
         3'b111:  return CMD_NOP;
         3'b011:  return CMD_ACT;
         3'b101:  return CMD_RD;
         3'b100:  return CMD_WR;
         3'b010:  return CMD_PRE;
         3'b001:  return CMD_REF;
         3'b000:  return CMD_MRS;
         default: return CMD_BST;
      endcase
   endfunction

   // clock cycles a burst occupies (two beats per cycle)
   function automatic logic [2:0] burst_cycles(input logic [2:0] bl);
      case (bl)
         3'b001:  return 3'd1;
         3'b010:  return 3'd2;
         3'b011:  return 3'd4;
         default: return 3'd0;
      endcase
   endfunction

   function automatic logic cas_ok(input logic [2:0] cl);
      return (cl == 3'b010) || (cl == 3'b110);
   endfunction

endpackage

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
   parameter int unsigned ROW_W = 13,
   parameter int unsigned CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_i,
   input  logic             close_i,
   input  logic             ap_i,
   input  logic [ROW_W-1:0] row_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             open_o,
   output logic [ROW_W-1:0] row_o,
   output logic             ap_pend_o
);

   logic [CNT_W-1:0] ap_cnt;

   assign ap_pend_o = (ap_cnt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_o <= 1'b0;
         row_o  <= '0;
         ap_cnt <= '0;
      end else if (close_i) begin
         open_o <= 1'b0;
         ap_cnt <= '0;
      end else if (act_i) begin
         open_o <= 1'b1;
         row_o  <= row_i;
      end else if (ap_i) begin
         ap_cnt <= len_i;
      end else if (ap_cnt != '0) begin
         ap_cnt <= ap_cnt - CNT_W'(1);
         if (ap_cnt == CNT_W'(1)) open_o <= 1'b0;
      end
   end

   // R2
   act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_i && !close_i |=> open_o && (row_o == $past(row_i)));

   // R4
   close_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      close_i |=> !open_o && !ap_pend_o);

   // R5
   pend_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ap_pend_o |-> open_o);

endmodule

// File: rtl/sdram_mode_regs.sv
module sdram_mode_regs #(
   parameter int unsigned        W          = 13,
   parameter int unsigned        DLL_BIT    = 8,
   parameter bit                 SELF_CLEAR = 1'b1,
   parameter logic [W-1:0]       MR_RESET   = 'h21
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         mr_wr,
   input  logic         emr_wr,
   input  logic [W-1:0] data_i,
   output logic [W-1:0] mr_o,
   output logic [W-1:0] emr_o
);

   localparam logic [W-1:0] CLR_MASK = SELF_CLEAR ? (W'(1) << DLL_BIT) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mr_o  <= MR_RESET;
         emr_o <= '0;
      end else begin
         if (mr_wr)  mr_o  <= data_i;
         else        mr_o  <= mr_o & ~CLR_MASK;
         if (emr_wr) emr_o <= data_i;
      end
   end

   generate
      if (SELF_CLEAR) begin : g_selfclr
         // R7
         dll_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mr_o[DLL_BIT] && !mr_wr |=> !mr_o[DLL_BIT]);
      end
   endgenerate

   // R9
   cas_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mr_o[6:4] == 3'b010 || mr_o[6:4] == 3'b110);

endmodule

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
   import sdram_trk_pkg::*;
#(
   parameter int unsigned BANK_W = 2,
   parameter int unsigned NB     = 4
) (
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [BANK_W-1:0] ba,
   input  logic              ap_bit,
   input  logic [2:0]        bl_field,
   input  logic [2:0]        cl_field,
   input  logic [NB-1:0]     bank_open,
   input  logic [NB-1:0]     ap_pend,
   input  logic              burst_busy,
   output cmd_e              cmd,
   output logic              illegal,
   output logic [NB-1:0]     act_vec,
   output logic [NB-1:0]     close_vec,
   output logic [NB-1:0]     ap_vec,
   output logic              rw_go,
   output logic              mr_wr,
   output logic              emr_wr
);

   logic any_open, sel_open, sel_pend, fields_ok;

   assign cmd       = decode_cmd(cs_n, ras_n, cas_n, we_n);
   assign any_open  = |bank_open;
   assign sel_open  = bank_open[ba];
   assign sel_pend  = ap_pend[ba];
   assign fields_ok = cas_ok(cl_field) && (burst_cycles(bl_field) != 3'd0);

   always_comb begin
      case (cmd)
         CMD_ACT:        illegal = sel_open;
         CMD_RD, CMD_WR: illegal = !sel_open || sel_pend;
         CMD_REF:        illegal = any_open;
         CMD_MRS:        illegal = any_open || burst_busy || (ba > BANK_W'(1)) ||
                                   ((ba == '0) && !fields_ok);
         default:        illegal = 1'b0;
      endcase
   end

   assign rw_go  = ((cmd == CMD_RD) || (cmd == CMD_WR)) && !illegal;
   assign mr_wr  = (cmd == CMD_MRS) && !illegal && (ba == BANK_W'(0));
   assign emr_wr = (cmd == CMD_MRS) && !illegal && (ba == BANK_W'(1));

   generate
      for (genvar i = 0; i < NB; i++) begin : g_bank
         logic hit;
         assign hit          = (ba == BANK_W'(i));
         assign act_vec[i]   = (cmd == CMD_ACT) && !illegal && hit;
         assign close_vec[i] = (cmd == CMD_PRE) && (ap_bit || hit);
         assign ap_vec[i]    = rw_go && ap_bit && hit;
      end
   endgenerate

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
   import sdram_trk_pkg::*;
#(
   parameter int unsigned    ROW_W    = 13,
   parameter int unsigned    BANK_W   = 2,
   parameter int unsigned    AP_BIT   = 10,
   parameter int unsigned    DLL_BIT  = 8,
   parameter bit             DLL_SELF_CLEAR = 1'b1,
   parameter logic [ROW_W-1:0] MR_RESET = 'h21
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cs_n,
   input  logic                     ras_n,
   input  logic                     cas_n,
   input  logic                     we_n,
   input  logic [BANK_W-1:0]        ba,
   input  logic [ROW_W-1:0]         addr,
   output logic [(1<<BANK_W)-1:0]   bank_open,
   output logic [(1<<BANK_W)*ROW_W-1:0] bank_row,
   output logic [2:0]               burst_len,
   output logic                     burst_interleave,
   output logic [2:0]               cas_lat,
   output logic [ROW_W-8:0]         op_mode,
   output logic [ROW_W-1:0]         ext_mode,
   output logic [3:0]               cmd_o,
   output logic                     illegal_o
);

   localparam int unsigned NB    = 1 << BANK_W;
   localparam int unsigned CNT_W = 3;

   generate
      if (ROW_W < 13)          begin : g_bad_row  $error("ROW_W must cover the mode fields"); end
      if (BANK_W < 1)          begin : g_bad_bank $error("BANK_W must be at least 1"); end
      if (AP_BIT >= ROW_W)     begin : g_bad_ap   $error("AP_BIT outside address"); end
      if (DLL_BIT >= ROW_W)    begin : g_bad_dll  $error("DLL_BIT outside address"); end
      if (!cas_ok(MR_RESET[6:4]) || burst_cycles(MR_RESET[2:0]) == 3'd0)
                               begin : g_bad_rst  $error("MR_RESET holds reserved fields"); end
   endgenerate

   cmd_e             cmd_now, cmd_q;
   logic             illegal_now, rw_go, mr_wr, emr_wr;
   logic [NB-1:0]    act_vec, close_vec, ap_vec, open_vec, pend_vec;
   logic [ROW_W-1:0] row_vec [NB];
   logic [ROW_W-1:0] mr, emr;
   logic [CNT_W-1:0] burst_cnt, len_now;

   assign len_now = burst_cycles(mr[2:0]);

   sdram_cmd_decode #(.BANK_W(BANK_W), .NB(NB)) u_dec (
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .ba(ba), .ap_bit(addr[AP_BIT]),
      .bl_field(addr[2:0]), .cl_field(addr[6:4]),
      .bank_open(open_vec), .ap_pend(pend_vec), .burst_busy(burst_cnt != '0),
      .cmd(cmd_now), .illegal(illegal_now),
      .act_vec(act_vec), .close_vec(close_vec), .ap_vec(ap_vec),
      .rw_go(rw_go), .mr_wr(mr_wr), .emr_wr(emr_wr)
   );

   generate
      for (genvar i = 0; i < NB; i++) begin : g_slot
         sdram_bank_slot #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .act_i(act_vec[i]), .close_i(close_vec[i]), .ap_i(ap_vec[i]),
            .row_i(addr), .len_i(len_now),
            .open_o(open_vec[i]), .row_o(row_vec[i]), .ap_pend_o(pend_vec[i])
         );
         assign bank_row[i*ROW_W +: ROW_W] = row_vec[i];
      end
   endgenerate

   sdram_mode_regs #(.W(ROW_W), .DLL_BIT(DLL_BIT), .SELF_CLEAR(DLL_SELF_CLEAR),
                     .MR_RESET(MR_RESET)) u_mode (
      .clk(clk), .rst_n(rst_n), .mr_wr(mr_wr), .emr_wr(emr_wr),
      .data_i(addr), .mr_o(mr), .emr_o(emr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         burst_cnt <= '0;
         cmd_q     <= CMD_DESEL;
         illegal_o <= 1'b0;
      end else begin
         if (rw_go)                burst_cnt <= len_now;
         else if (burst_cnt != '0) burst_cnt <= burst_cnt - CNT_W'(1);
         cmd_q     <= cmd_now;
         illegal_o <= illegal_now;
      end
   end

   assign bank_open        = open_vec;
   assign burst_len        = mr[2:0];
   assign burst_interleave = mr[3];
   assign cas_lat          = mr[6:4];
   assign op_mode          = mr[ROW_W-1:7];
   assign ext_mode         = emr;
   assign cmd_o            = cmd_q;

   // R8
   mrs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mr_wr || emr_wr) |-> (open_vec == '0) && (pend_vec == '0));

   // R3
   rw_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rw_go |-> open_vec[ba]);

   // R2
   act_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_vec != '0) |-> $onehot0(act_vec) && !open_vec[ba]);

endmodule

// File: tb/sim_sdram_cmd_tracker.sv
module sim_sdram_cmd_tracker;
   localparam int CLK_PERIOD = 10;

   localparam logic [3:0] P_DES = 4'b1111, P_NOP = 4'b0111, P_ACT = 4'b0011,
                          P_RD  = 4'b0101, P_WR  = 4'b0100, P_PRE = 4'b0010,
                          P_REF = 4'b0001, P_MRS = 4'b0000, P_BST = 4'b0110;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0]  ba = '0;
   logic [12:0] addr = '0;
   logic [3:0]  bank_open;
   logic [51:0] bank_row;
   logic [2:0]  burst_len, cas_lat;
   logic        burst_interleave, illegal_o;
   logic [5:0]  op_mode;
   logic [12:0] ext_mode;
   logic [3:0]  cmd_o;

   int checks = 0, errors = 0;

   logic [3:0]  m_open;
   logic [12:0] m_row [4];
   int          m_ap  [4];
   int          m_burst;
   logic [12:0] m_mr, m_emr;
   int          m_cmd;
   logic        m_ill;

   sdram_cmd_tracker u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .ba(ba), .addr(addr), .bank_open(bank_open), .bank_row(bank_row),
      .burst_len(burst_len), .burst_interleave(burst_interleave), .cas_lat(cas_lat),
      .op_mode(op_mode), .ext_mode(ext_mode), .cmd_o(cmd_o), .illegal_o(illegal_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int code_of(input logic [3:0] p);
      if (p[3]) return 0;
      case (p[2:0])
         3'b111: return 1;  3'b011: return 2;  3'b101: return 3;  3'b100: return 4;
         3'b010: return 5;  3'b001: return 6;  3'b000: return 7;  default: return 8;
      endcase
   endfunction

   function automatic int half_of(input logic [2:0] bl);
      return (bl == 3'b001) ? 1 : (bl == 3'b010) ? 2 : (bl == 3'b011) ? 4 : 0;
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_open = '0; m_burst = 0; m_mr = 13'h021; m_emr = '0; m_cmd = 0; m_ill = 1'b0;
      for (int i = 0; i < 4; i++) begin m_row[i] = '0; m_ap[i] = 0; end
   endtask

   task automatic model_step(input logic [3:0] p, input logic [1:0] b, input logic [12:0] a);
      int  c = code_of(p);
      bit  ill = 1'b0;
      bit  okf = ((a[6:4] == 3'b010) || (a[6:4] == 3'b110)) && (half_of(a[2:0]) != 0);
      int  h = half_of(m_mr[2:0]);
      case (c)
         2: ill = m_open[b];
         3, 4: ill = !m_open[b] || (m_ap[b] != 0);
         6: ill = (m_open != 0);
         7: ill = (m_open != 0) || (m_burst != 0) || b[1] || ((b == 2'd0) && !okf);
         default: ill = 1'b0;
      endcase
      for (int i = 0; i < 4; i++)
         if (m_ap[i] != 0) begin
            if (m_ap[i] == 1) m_open[i] = 1'b0;
            m_ap[i]--;
         end
      if (!ill && (c == 3 || c == 4)) m_burst = h;
      else if (m_burst > 0) m_burst--;
      if (c == 2 && !ill) begin m_open[b] = 1'b1; m_row[b] = a; end
      if ((c == 3 || c == 4) && !ill && a[10]) m_ap[b] = h;
      if (c == 5)
         for (int i = 0; i < 4; i++)
            if (a[10] || b == 2'(i)) begin m_open[i] = 1'b0; m_ap[i] = 0; end
      m_mr[8] = 1'b0;
      if (c == 7 && !ill && b == 2'd0) m_mr = a;
      if (c == 7 && !ill && b == 2'd1) m_emr = a;
      m_cmd = c;
      m_ill = ill;
   endtask

   task automatic check_all();
      chk("R2 R4 R5", "bank_open", 32'(bank_open), 32'(m_open));
      for (int i = 0; i < 4; i++) chk("R2", "bank_row", 32'(bank_row[i*13 +: 13]), 32'(m_row[i]));
      chk("R6", "burst_len", 32'(burst_len), 32'(m_mr[2:0]));
      chk("R6", "burst_interleave", 32'(burst_interleave), 32'(m_mr[3]));
      chk("R6", "cas_lat", 32'(cas_lat), 32'(m_mr[6:4]));
      chk("R6 R7", "op_mode", 32'(op_mode), 32'(m_mr[12:7]));
      chk("R6", "ext_mode", 32'(ext_mode), 32'(m_emr));
      chk("R1", "cmd_o", 32'(cmd_o), 32'(m_cmd));
      chk("R3 R8 R9 R10", "illegal_o", 32'(illegal_o), 32'(m_ill));
   endtask

   task automatic issue(input logic [3:0] p, input logic [1:0] b, input logic [12:0] a);
      @(negedge clk);
      {cs_n, ras_n, cas_n, we_n} = p;
      ba = b;
      addr = a;
      model_step(p, b, a);
      @(posedge clk);
      #1;
      check_all();
   endtask

   initial begin
      void'($urandom(32'd2025));
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      // R11 reset state
      chk("R11", "bank_open", 32'(bank_open), 32'h0);
      chk("R11", "mode", 32'({op_mode, cas_lat, burst_interleave, burst_len}), 32'h021);
      chk("R11", "ext_mode", 32'(ext_mode), 32'h0);
      chk("R11", "cmd_o", 32'(cmd_o), 32'h0);
      chk("R11", "illegal_o", 32'(illegal_o), 32'h0);
      @(negedge clk) rst_n = 1'b1;

      // R1 every command code
      issue(P_NOP, 0, 0);  chk("R1", "nop", 32'(cmd_o), 1);
      issue(P_DES, 0, 0);  chk("R1", "deselect", 32'(cmd_o), 0);
      issue(P_BST, 0, 0);  chk("R1", "burst stop", 32'(cmd_o), 8);
      issue(P_REF, 0, 0);  chk("R1", "refresh", 32'(cmd_o), 6);
      // R6 mode and extended mode load
      issue(P_MRS, 0, 13'b000000_110_1_011);
      chk("R6", "bl", 32'(burst_len), 3); chk("R6", "cl", 32'(cas_lat), 6);
      chk("R6", "bt", 32'(burst_interleave), 1);
      issue(P_MRS, 1, 13'h1A5); chk("R6", "emr", 32'(ext_mode), 32'h1A5);
      // R7 DLL reset self-clear
      issue(P_MRS, 0, 13'b000010_010_0_010);
      chk("R7", "dll set", 32'(op_mode[1]), 1);
      issue(P_NOP, 0, 0);
      chk("R7", "dll cleared", 32'(op_mode[1]), 0);
      // R9 reserved fields
      issue(P_MRS, 0, 13'b000000_011_0_010); chk("R9", "bad cl", 32'(illegal_o), 1);
      issue(P_MRS, 0, 13'b000000_010_0_111); chk("R9", "bad bl", 32'(illegal_o), 1);
      issue(P_MRS, 2, 13'h0); chk("R9", "bad ba", 32'(illegal_o), 1);
      // R2 activate and double activate
      issue(P_ACT, 2, 13'h1ABC); chk("R2", "row2", 32'(bank_row[26 +: 13]), 32'h1ABC);
      issue(P_ACT, 2, 13'h0111); chk("R2", "reopen", 32'(illegal_o), 1);
      chk("R2", "row kept", 32'(bank_row[26 +: 13]), 32'h1ABC);
      // R3 read to idle bank
      issue(P_RD, 1, 13'h0); chk("R3", "rd idle", 32'(illegal_o), 1);
      issue(P_WR, 2, 13'h0); chk("R3", "wr open", 32'(bank_open[2]), 1);
      // R10 refresh with bank open
      issue(P_REF, 0, 0); chk("R10", "refresh open", 32'(illegal_o), 1);
      // R4 selective then all
      issue(P_ACT, 0, 13'h5); issue(P_ACT, 3, 13'h7);
      issue(P_PRE, 2, 13'h0); chk("R4", "single", 32'(bank_open), 32'b1001);
      issue(P_PRE, 0, 13'h0400); chk("R4", "all", 32'(bank_open), 0);
      // R5 auto precharge coinciding with precharge of another bank (BL 4)
      issue(P_MRS, 0, 13'h022);
      issue(P_ACT, 0, 13'h10); issue(P_ACT, 1, 13'h11);
      issue(P_RD, 0, 13'h0400);
      issue(P_RD, 0, 13'h0000); chk("R3", "rd pending", 32'(illegal_o), 1);
      issue(P_PRE, 1, 13'h0); chk("R5", "both idle", 32'(bank_open), 0);
      // R8 burst in progress with all banks idle
      issue(P_ACT, 3, 13'h3); issue(P_RD, 3, 13'h0); issue(P_PRE, 3, 13'h0);
      issue(P_MRS, 0, 13'h021); chk("R8", "mrs in burst", 32'(illegal_o), 1);
      issue(P_MRS, 0, 13'h021); chk("R8", "mrs after burst", 32'(illegal_o), 0);

      // constrained random
      for (int n = 0; n < 3000; n++) begin
         int r = $urandom % 100;
         logic [1:0]  b = 2'($urandom % 4);
         logic [12:0] a = 13'($urandom);
         if (r < 16)      issue(P_ACT, b, a);
         else if (r < 30) issue(P_RD, b, a & 13'h0407);
         else if (r < 42) issue(P_WR, b, a & 13'h0407);
         else if (r < 55) issue(P_PRE, b, ($urandom % 3 == 0) ? 13'h0400 : 13'h0);
         else if (r < 68) begin
            logic [2:0] cl = ($urandom % 4 == 0) ? 3'($urandom) : (($urandom % 2) ? 3'b010 : 3'b110);
            logic [2:0] bl = ($urandom % 4 == 0) ? 3'($urandom) : 3'(1 + $urandom % 3);
            logic [1:0] mb = ($urandom % 5 == 0) ? 2'($urandom) : 2'($urandom % 2);
            if ($urandom % 2) begin
               issue(P_PRE, 0, 13'h0400);
               repeat (4) issue(P_NOP, 0, 0);
            end
            issue(P_MRS, mb, {6'($urandom), cl, 1'($urandom), bl});
         end
         else if (r < 72) issue(P_REF, b, a);
         else if (r < 82) issue(P_NOP, b, a);
         else if (r < 90) issue(P_DES, b, a);
         else             issue(P_BST, b, a);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule